// File: doc/BRIEF.md
# Port Error Recovery Escalation Controller

This block supervises a group of link ports and answers each port's error and link-loss indications with recovery actions of rising severity. A port first receives link retrain requests. If those keep failing, it receives port reset requests, then domain isolate requests. If isolation also keeps failing, the port raises a held escalation request to logic outside the block. Each action is a one-cycle pulse on that port's own output.

Before every attempt the port waits out a backoff delay. The delay grows with the retry count and is offset by the port's index, so neighbouring ports do not retry in lockstep. A port counts as recovered only after its link has stayed up for a whole stability window. Recoveries that come too close together put the port into a degraded mode. Global-impact events, isolation entries and degrade entries share one prioritized alert channel, which reports a level and a port mask.

Top module: `port_recovery_ladder`

## Requirements
- R1: The actions climb in a fixed order: retrain, then port reset, then isolate. Each action is a one-cycle pulse on the port's `retrain`, `port_rst` or `isolate` output, and only one of the three is active at a time.
- R2: Each step allows MAX_RETRY attempts. When the last attempt at a step fails, the port moves to the next step with its retry count back at 0. When the last isolate attempt fails, `esc_req` is raised and held until `sw_clr` for that port. While `esc_req` is high, no further actions are issued.
- R3: The backoff for retry r on port p is D = min((BASE_DLY + p*PORT_SKEW) << r, MAX_DLY). If backoff begins at clock edge k, the action pulse is visible after edge k+D+1 and not before.
- R4: After an action, the port sees a stability phase starting at the next edge. `rec_done` pulses after STAB_WIN consecutive link-up samples. A single link-down sample in this phase consumes one retry and starts a new backoff at that edge.
- R5: In idle, an `err_pulse` or a falling edge of `link_up` starts recovery at the retrain step with retry 0. A completed recovery clears the step and the retry count.
- R6: With DEG_CNT=3, the port enters degraded mode when a recovery completes no more than RATE_WIN cycles after the completion two recoveries earlier. The `degraded` output rises in the same cycle as that `rec_done`, together with an alert of level 1 whose mask has the port's bit set.
- R7: A degraded port ignores error pulses and link drops: none of its actions fire. `sw_clr` clears `degraded` and wipes the recovery history.
- R8: In the cycle after an isolate pulse, the alert output shows level 2 with the isolating ports' bits set in the mask.
- R9: In the cycle after `global_impact` is sampled high, the alert output shows level 3 with every mask bit set. This alert wins over any isolate or degrade alert from the same cycle. Alerts last one cycle.
- R10: During and right after reset, all actions, `esc_req`, `rec_done`, `degraded` and the alert outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_pulse | input | NPORTS | Per-port error indication, one-cycle pulse |
| link_up | input | NPORTS | Per-port link-up status |
| sw_clr | input | NPORTS | Clears degraded mode and a held escalation |
| global_impact | input | 1 | Global-impact event flag |
| retrain | output | NPORTS | Retrain request pulse |
| port_rst | output | NPORTS | Port reset request pulse |
| isolate | output | NPORTS | Domain isolate request pulse |
| esc_req | output | NPORTS | Held escalation request |
| rec_done | output | NPORTS | Recovered pulse |
| degraded | output | NPORTS | Degraded-mode flag |
| alert_valid | output | 1 | Alert present this cycle |
| alert_lvl | output | 2 | 3 global, 2 isolate, 1 degrade |
| alert_ports | output | NPORTS | Ports named by the alert |

## Verification
Every result has a fixed cycle offset from the edge that sampled its cause:
- an action pulse comes D+1 edges after backoff starts;
- `rec_done` comes STAB_WIN edges after the edge that follows the action;
- a retry after a link drop starts two edges after the action;
- alerts come exactly one edge after their event;
- `degraded` rises on the same edge as the third close `rec_done`.

The bench recomputes D from the formula in R3 for each attempt. It advances exactly that many edges, confirms that no action is visible one cycle early, and then samples the expected pulse. All inputs are driven, and all outputs sampled, one time unit after a rising edge.

// File: rtl/prl_pkg.sv
// Shared types for the port recovery ladder.
// Assumes: nothing beyond SystemVerilog packages.
package prl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BACKOFF,
        ST_ACT,
        ST_STABLE,
        ST_ESC
    } pst_e;

    typedef enum logic [1:0] {
        STEP_RETRAIN,
        STEP_RESET,
        STEP_ISOLATE
    } step_e;

    localparam logic [1:0] ALV_NONE    = 2'd0;
    localparam logic [1:0] ALV_DEGRADE = 2'd1;
    localparam logic [1:0] ALV_ISOLATE = 2'd2;
    localparam logic [1:0] ALV_GLOBAL  = 2'd3;

endpackage

// File: rtl/prl_port_seq.sv
// Per-port escalation sequencer: backoff, action pulse, stability window,
// bounded retries per step, escalation hold and degraded flag.
// Assumes: err_pulse is a one-cycle pulse; burst comes from the rate history.
module prl_port_seq
    import prl_pkg::*;
#(
    parameter int MAX_RETRY = 3,
    parameter int BASE_DLY  = 4,
    parameter int PORT_SKEW = 3,
    parameter int MAX_DLY   = 20,
    parameter int STAB_WIN  = 8,
    parameter int PORT_IDX  = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic err_pulse,
    input  logic link_up,
    input  logic sw_clr,
    input  logic burst,
    output logic retrain,
    output logic port_rst,
    output logic isolate,
    output logic esc_req,
    output logic rec_done,
    output logic degraded,
    output logic rec_evt,
    output logic iso_evt
);
    localparam int TW = $clog2(MAX_DLY + 1);
    localparam int RW = $clog2(MAX_RETRY + 1);
    localparam int WW = (STAB_WIN > 1) ? $clog2(STAB_WIN) : 1;

    pst_e          state_q;
    step_e         step_q;
    logic [RW-1:0] retry_q;
    logic [TW-1:0] tmr_q;
    logic [WW-1:0] win_q;
    logic          link_q;
    logic          deg_q;
    logic          rec_q;
    logic          trig;
    logic          last_try;

    // Skewed, doubling, capped backoff length for a given retry index.
    function automatic logic [TW-1:0] bo_delay(input logic [RW-1:0] r);
        int unsigned d;
        d = (BASE_DLY + PORT_IDX * PORT_SKEW) << r;
        if (d > MAX_DLY) d = MAX_DLY;
        return TW'(d);
    endfunction

    // Start, retry-limit and completion conditions.
    always_comb begin
        trig     = (err_pulse | (link_q & ~link_up)) & ~deg_q;
        last_try = (retry_q == RW'(MAX_RETRY - 1));
        rec_evt  = (state_q == ST_STABLE) && link_up && (win_q == WW'(STAB_WIN - 1));
        iso_evt  = (state_q == ST_ACT) && (step_q == STEP_ISOLATE);
    end

    assign retrain  = (state_q == ST_ACT) && (step_q == STEP_RETRAIN);
    assign port_rst = (state_q == ST_ACT) && (step_q == STEP_RESET);
    assign isolate  = iso_evt;
    assign esc_req  = (state_q == ST_ESC);
    assign rec_done = rec_q;
    assign degraded = deg_q;

    // Escalation state machine with its timers and retry counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= STEP_RETRAIN;
            retry_q <= '0;
            tmr_q   <= '0;
            win_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (trig) begin
                        state_q <= ST_BACKOFF;
                        step_q  <= STEP_RETRAIN;
                        retry_q <= '0;
                        tmr_q   <= bo_delay('0);
                    end
                end
                ST_BACKOFF: begin
                    if (tmr_q == '0) state_q <= ST_ACT;
                    else             tmr_q   <= tmr_q - 1'b1;
                end
                ST_ACT: begin
                    state_q <= ST_STABLE;
                    win_q   <= '0;
                end
                ST_STABLE: begin
                    if (!link_up) begin
                        if (!last_try) begin
                            retry_q <= retry_q + 1'b1;
                            tmr_q   <= bo_delay(RW'(retry_q + 1'b1));
                            state_q <= ST_BACKOFF;
                        end else if (step_q == STEP_ISOLATE) begin
                            state_q <= ST_ESC;
                        end else begin
                            step_q  <= step_e'(step_q + 1'b1);
                            retry_q <= '0;
                            tmr_q   <= bo_delay('0);
                            state_q <= ST_BACKOFF;
                        end
                    end else if (win_q == WW'(STAB_WIN - 1)) begin
                        state_q <= ST_IDLE;
                        step_q  <= STEP_RETRAIN;
                        retry_q <= '0;
                    end else begin
                        win_q <= win_q + 1'b1;
                    end
                end
                ST_ESC: begin
                    if (sw_clr) begin
                        state_q <= ST_IDLE;
                        step_q  <= STEP_RETRAIN;
                        retry_q <= '0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Link edge history, recovered pulse and degraded flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q <= 1'b0;
            rec_q  <= 1'b0;
            deg_q  <= 1'b0;
        end else begin
            link_q <= link_up;
            rec_q  <= rec_evt;
            if (sw_clr)     deg_q <= 1'b0;
            else if (burst) deg_q <= 1'b1;
        end
    end

endmodule

// File: rtl/prl_rate_hist.sv
// Exact sliding-window recovery history: keeps the ages of the last
// DEG_CNT-1 recoveries and flags a recovery that completes a close burst.
// Assumes: DEG_CNT >= 2; ages saturate at RATE_WIN, meaning "too old".
module prl_rate_hist #(
    parameter int RATE_WIN = 200,
    parameter int DEG_CNT  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rec_evt,
    input  logic clr,
    output logic burst
);
    localparam int NS = DEG_CNT - 1;
    localparam int AW = $clog2(RATE_WIN + 1);
    localparam logic [AW-1:0] AMAX = AW'(RATE_WIN);

    logic [AW-1:0] age_q [NS];

    // Saturating one-step ageing.
    function automatic logic [AW-1:0] aged(input logic [AW-1:0] a);
        return (a >= AMAX) ? AMAX : a + 1'b1;
    endfunction

    for (genvar g = 0; g < NS; g++) begin : g_slot
        if (g == 0) begin : g_head
            // Newest slot: restart at zero on a recovery, else age.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) age_q[g] <= AMAX;
                else if (rec_evt)  age_q[g] <= '0;
                else               age_q[g] <= aged(age_q[g]);
            end
        end else begin : g_tail
            // Older slots: shift down on a recovery, else age.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) age_q[g] <= AMAX;
                else if (rec_evt)  age_q[g] <= aged(age_q[g-1]);
                else               age_q[g] <= aged(age_q[g]);
            end
        end
    end

    assign burst = rec_evt && (age_q[NS-1] < AMAX);

endmodule

// File: rtl/prl_alert_arb.sv
// Prioritized alert register: global over isolate over degrade.
// Assumes: event inputs are single-cycle; lower-priority events in the
// same cycle as a higher one are not reported separately.
module prl_alert_arb
    import prl_pkg::*;
#(
    parameter int NPORTS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              global_impact,
    input  logic [NPORTS-1:0] iso_evt,
    input  logic [NPORTS-1:0] deg_evt,
    output logic              alert_valid,
    output logic [1:0]        alert_lvl,
    output logic [NPORTS-1:0] alert_ports
);
    logic              nxt_v;
    logic [1:0]        nxt_l;
    logic [NPORTS-1:0] nxt_m;

    // Pick the highest-priority event of this cycle.
    always_comb begin
        nxt_v = 1'b0;
        nxt_l = ALV_NONE;
        nxt_m = '0;
        if (global_impact) begin
            nxt_v = 1'b1;
            nxt_l = ALV_GLOBAL;
            nxt_m = '1;
        end else if (|iso_evt) begin
            nxt_v = 1'b1;
            nxt_l = ALV_ISOLATE;
            nxt_m = iso_evt;
        end else if (|deg_evt) begin
            nxt_v = 1'b1;
            nxt_l = ALV_DEGRADE;
            nxt_m = deg_evt;
        end
    end

    // Register the chosen alert for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alert_valid <= 1'b0;
            alert_lvl   <= ALV_NONE;
            alert_ports <= '0;
        end else begin
            alert_valid <= nxt_v;
            alert_lvl   <= nxt_l;
            alert_ports <= nxt_m;
        end
    end

endmodule

// File: rtl/port_recovery_ladder.sv
// Top: one sequencer and one rate history per port, plus a shared alert
// arbiter. Assumes synchronous active-low reset and one clock domain.
module port_recovery_ladder #(
    parameter int NPORTS    = 2,
    parameter int MAX_RETRY = 3,
    parameter int BASE_DLY  = 4,
    parameter int PORT_SKEW = 3,
    parameter int MAX_DLY   = 20,
    parameter int STAB_WIN  = 8,
    parameter int RATE_WIN  = 200,
    parameter int DEG_CNT   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] err_pulse,
    input  logic [NPORTS-1:0] link_up,
    input  logic [NPORTS-1:0] sw_clr,
    input  logic              global_impact,
    output logic [NPORTS-1:0] retrain,
    output logic [NPORTS-1:0] port_rst,
    output logic [NPORTS-1:0] isolate,
    output logic [NPORTS-1:0] esc_req,
    output logic [NPORTS-1:0] rec_done,
    output logic [NPORTS-1:0] degraded,
    output logic              alert_valid,
    output logic [1:0]        alert_lvl,
    output logic [NPORTS-1:0] alert_ports
);
    logic [NPORTS-1:0] rec_evt;
    logic [NPORTS-1:0] iso_evt;
    logic [NPORTS-1:0] burst;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        prl_port_seq #(
            .MAX_RETRY(MAX_RETRY),
            .BASE_DLY (BASE_DLY),
            .PORT_SKEW(PORT_SKEW),
            .MAX_DLY  (MAX_DLY),
            .STAB_WIN (STAB_WIN),
            .PORT_IDX (p)
        ) u_seq (
            .clk      (clk),
            .rst_n    (rst_n),
            .err_pulse(err_pulse[p]),
            .link_up  (link_up[p]),
            .sw_clr   (sw_clr[p]),
            .burst    (burst[p]),
            .retrain  (retrain[p]),
            .port_rst (port_rst[p]),
            .isolate  (isolate[p]),
            .esc_req  (esc_req[p]),
            .rec_done (rec_done[p]),
            .degraded (degraded[p]),
            .rec_evt  (rec_evt[p]),
            .iso_evt  (iso_evt[p])
        );

        prl_rate_hist #(
            .RATE_WIN(RATE_WIN),
            .DEG_CNT (DEG_CNT)
        ) u_hist (
            .clk    (clk),
            .rst_n  (rst_n),
            .rec_evt(rec_evt[p]),
            .clr    (sw_clr[p]),
            .burst  (burst[p])
        );
    end

    prl_alert_arb #(.NPORTS(NPORTS)) u_alert (
        .clk          (clk),
        .rst_n        (rst_n),
        .global_impact(global_impact),
        .iso_evt      (iso_evt),
        .deg_evt      (burst),
        .alert_valid  (alert_valid),
        .alert_lvl    (alert_lvl),
        .alert_ports  (alert_ports)
    );

endmodule

// File: rtl/prl_checker.sv
// Temporal checks on the recovery ladder, bound to the top module.
// Assumes the port names of port_recovery_ladder.
module prl_checker #(
    parameter int NPORTS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPORTS-1:0] link_up,
    input logic [NPORTS-1:0] sw_clr,
    input logic              global_impact,
    input logic [NPORTS-1:0] retrain,
    input logic [NPORTS-1:0] port_rst,
    input logic [NPORTS-1:0] isolate,
    input logic [NPORTS-1:0] esc_req,
    input logic [NPORTS-1:0] rec_done,
    input logic [NPORTS-1:0] degraded,
    input logic              alert_valid,
    input logic [1:0]        alert_lvl,
    input logic [NPORTS-1:0] alert_ports
);
    for (genvar p = 0; p < NPORTS; p++) begin : g_chk
        a_r1_one_action: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({isolate[p], port_rst[p], retrain[p]}));
        a_r1_retrain_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            retrain[p] |=> !retrain[p]);
        a_r2_esc_held: assert property (@(posedge clk) disable iff (!rst_n)
            esc_req[p] && !sw_clr[p] |=> esc_req[p]);
        a_r2_esc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            esc_req[p] |-> !retrain[p] && !port_rst[p] && !isolate[p]);
        a_r4_rec_link_up: assert property (@(posedge clk) disable iff (!rst_n)
            rec_done[p] |-> $past(link_up[p]));
        a_r6_deg_alert: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(degraded[p]) |-> alert_valid);
        a_r7_deg_held: assert property (@(posedge clk) disable iff (!rst_n)
            degraded[p] && !sw_clr[p] |=> degraded[p]);
        a_r8_iso_alert: assert property (@(posedge clk) disable iff (!rst_n)
            isolate[p] |=> alert_valid && alert_ports[p] && (alert_lvl >= 2'd2));
    end

    a_r9_global_alert: assert property (@(posedge clk) disable iff (!rst_n)
        global_impact |=> alert_valid && (alert_lvl == 2'd3) && (&alert_ports));

endmodule

bind port_recovery_ladder prl_checker #(.NPORTS(NPORTS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_up      (link_up),
    .sw_clr       (sw_clr),
    .global_impact(global_impact),
    .retrain      (retrain),
    .port_rst     (port_rst),
    .isolate      (isolate),
    .esc_req      (esc_req),
    .rec_done     (rec_done),
    .degraded     (degraded),
    .alert_valid  (alert_valid),
    .alert_lvl    (alert_lvl),
    .alert_ports  (alert_ports)
);

// File: tb/sim_port_recovery_ladder.sv
// Self-checking bench: a vector table of recovery episodes, then directed
// tests for reset, degrade, escalation and alert priority.
module sim_port_recovery_ladder;
    localparam int NP = 2;
    localparam int MR = 3;
    localparam int BD = 4;
    localparam int SK = 3;
    localparam int MD = 20;
    localparam int SW = 8;
    localparam int RWIN = 200;
    localparam int TOTAL = 3 * MR;

    // {expected final step[9:8], port[7:4], link drops[3:0]}
    localparam int NV = 6;
    localparam logic [9:0] VEC [NV] = '{
        10'h000, 10'h010, 10'h001, 10'h012, 10'h103, 10'h206
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] err_pulse = '0;
    logic [NP-1:0] link_up = '1;
    logic [NP-1:0] sw_clr = '0;
    logic          global_impact = 1'b0;
    logic [NP-1:0] retrain, port_rst, isolate, esc_req, rec_done, degraded;
    logic          alert_valid;
    logic [1:0]    alert_lvl;
    logic [NP-1:0] alert_ports;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    port_recovery_ladder u0 (
        .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .link_up(link_up),
        .sw_clr(sw_clr), .global_impact(global_impact), .retrain(retrain),
        .port_rst(port_rst), .isolate(isolate), .esc_req(esc_req),
        .rec_done(rec_done), .degraded(degraded), .alert_valid(alert_valid),
        .alert_lvl(alert_lvl), .alert_ports(alert_ports)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_delay(input int p, input int r);
        int d;
        d = (BD + p * SK) << r;
        return (d > MD) ? MD : d;
    endfunction

    function automatic int acts(input int p);
        return {29'd0, isolate[p], port_rst[p], retrain[p]};
    endfunction

    // One recovery episode: 'drops' failed attempts, then success (if left).
    task automatic run_episode(input int p, input int drops, input bit glob,
                               output int last_step);
        err_pulse[p] = 1'b1;
        tick();
        err_pulse[p] = 1'b0;
        last_step = -1;
        for (int a = 0; a < TOTAL && a <= drops; a++) begin
            int stp = a / MR;
            int d = exp_delay(p, a % MR);
            repeat (d) tick();
            chk("R3 no action before backoff ends", acts(p), 0);
            tick();
            chk("R1 R3 action type at backoff end", acts(p), 1 << stp);
            last_step = stp;
            if (stp == 2 && glob) global_impact = 1'b1;
            if (a < drops) link_up[p] = 1'b0;
            tick();
            global_impact = 1'b0;
            if (stp == 2) begin
                chk("R8 R9 alert after isolate", alert_valid, 1);
                chk("R8 R9 alert level", alert_lvl, glob ? 3 : 2);
                chk("R8 R9 alert mask", alert_ports, glob ? 3 : (1 << p));
            end
            if (a < drops) begin
                tick();
                link_up[p] = 1'b1;
                if (a == TOTAL - 1) chk("R2 escalation raised", esc_req[p], 1);
            end else begin
                repeat (SW - 1) tick();
                chk("R4 not recovered before window", rec_done[p], 0);
                tick();
                chk("R4 recovered after window", rec_done[p], 1);
            end
        end
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int ls;
        int seen;
        repeat (3) tick();
        // R10: reset state
        chk("R10 actions in reset", {retrain, port_rst, isolate}, 0);
        chk("R10 esc/deg/rec in reset", {esc_req, degraded, rec_done}, 0);
        rst_n = 1'b1;
        tick();
        chk("R10 alert after reset", {alert_valid, alert_lvl, alert_ports}, 0);
        chk("R10 outputs after reset", {retrain, port_rst, isolate, esc_req, rec_done, degraded}, 0);

        // Table walk: R1 R3 R4 R5 per vector
        for (int i = 0; i < NV; i++) begin
            run_episode(int'(VEC[i][7:4]), int'(VEC[i][3:0]), 1'b0, ls);
            chk("R5 R1 final step of episode", ls, int'(VEC[i][9:8]));
            chk("R6 no degrade on spaced recoveries", degraded, 0);
            repeat (RWIN + 10) tick();
        end

        // R6: three close recoveries on port 0 enter degraded mode
        run_episode(0, 0, 1'b0, ls);
        run_episode(0, 0, 1'b0, ls);
        chk("R6 not degraded after two", degraded[0], 0);
        run_episode(0, 0, 1'b0, ls);
        chk("R6 degraded after third", degraded[0], 1);
        chk("R6 degrade alert valid", alert_valid, 1);
        chk("R6 degrade alert level", alert_lvl, 1);
        chk("R6 degrade alert mask", alert_ports, 1);

        // R7: error pulse and link drop ignored while degraded
        seen = 0;
        err_pulse[0] = 1'b1;
        tick();
        err_pulse[0] = 1'b0;
        for (int c = 0; c < 40; c++) begin
            if (c == 10) link_up[0] = 1'b0;
            if (c == 12) link_up[0] = 1'b1;
            tick();
            seen |= acts(0);
        end
        chk("R7 no action while degraded", seen, 0);
        chk("R7 still degraded", degraded[0], 1);
        sw_clr[0] = 1'b1;
        tick();
        sw_clr[0] = 1'b0;
        chk("R7 cleared by sw_clr", degraded[0], 0);

        // R6: two close then one late recovery do not degrade
        run_episode(0, 0, 1'b0, ls);
        chk("R7 episode works after clear", ls, 0);
        run_episode(0, 0, 1'b0, ls);
        repeat (RWIN + 10) tick();
        run_episode(0, 0, 1'b0, ls);
        chk("R6 late third recovery not degraded", degraded[0], 0);
        repeat (RWIN + 10) tick();

        // R9: global alert wins over a same-cycle isolation alert
        run_episode(1, 6, 1'b1, ls);
        chk("R9 priority episode recovered at isolate", ls, 2);
        repeat (RWIN + 10) tick();

        // R2: exhausting every step raises a held escalation
        run_episode(1, 9, 1'b0, ls);
        seen = 0;
        for (int c = 0; c < 30; c++) begin
            tick();
            seen |= acts(1);
        end
        chk("R2 escalation held", esc_req[1], 1);
        chk("R2 no action while escalated", seen, 0);
        sw_clr[1] = 1'b1;
        tick();
        sw_clr[1] = 1'b0;
        chk("R2 escalation released by sw_clr", esc_req[1], 0);

        // R9: global alert alone, one cycle long
        global_impact = 1'b1;
        tick();
        global_impact = 1'b0;
        chk("R9 global alert level", alert_lvl, 3);
        chk("R9 global alert mask", alert_ports, 3);
        tick();
        chk("R9 alert lasts one cycle", alert_valid, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule